// File: doc/BRIEF.md
# UART Automatic Modem Flow Control

This block sits between a UART's receive FIFO, its transmit serializer and the two modem handshake pins. It throttles traffic in both directions with no software involvement. On the transmit side it synchronizes the incoming clear-to-send pin and stops new characters from starting while the far end reports busy. A character that is already being shifted out always completes.

On the receive side it drives the request-to-send pin from the receive FIFO fill count, with hysteresis across a four-rung trigger ladder. The pin goes busy at the rung above the programmed trigger. It releases only when the fill falls below the rung beneath the programmed trigger. The block also raises an interrupt request whenever the fill is at or above the programmed trigger.

A single 8-bit configuration register holds the two enable bits and the trigger selection. Reading it back shows the live receive-side flow-control state in place of the stored enable bit.

Top module: `uart_autoflow`

## Requirements
- R1: After reset, both automatic enables are off, the trigger select is 0, `cfg_rdata` reads 0, `rx_irq` is 0, and `rts_pin` equals `sw_rts`.
- R2: A write with `cfg_we` high loads the register on that edge, with these fields:
  - bit 7 is the automatic CTS enable;
  - bit 6 is the automatic RTS enable;
  - bits 1:0 are the trigger select.

  On read-back, bit 7 and bits 1:0 return the stored value, and bits 5:2 read 0.
- R3: With automatic CTS enabled, a logic 1 on `cts_pin` blocks `tx_start`. A change on the pin takes effect two clock edges later, through a two-flop synchronizer. With the enable off, `cts_pin` has no effect on `tx_start`.
- R4: `tx_start` is high only when `tx_req` is high and `tx_busy` is low, so gating acts only at character boundaries.
- R5: The trigger ladder is 8, 16, 56 and 60 characters, for select values 0, 1, 2 and 3. `rx_irq` becomes 1 one edge after `rx_fill` is at or above the selected level. It stays 1 until the fill falls below that level.
- R6: With automatic RTS enabled, `rts_pin` goes to 1 one edge after `rx_fill` reaches the rung above the selected one. That level saturates at 60. `rts_pin` returns to 0 one edge after the fill drops below the rung below the selected one. That level saturates at 8. Between the two levels, the pin holds its state.
- R7: With automatic RTS disabled, `rts_pin` equals `sw_rts` in the same cycle, and the hysteresis state is cleared on each edge.
- R8: Read-back bit 6 is 1 exactly when automatic RTS is enabled and the block is currently driving `rts_pin` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read-back with live RTS status in bit 6 |
| rx_fill | input | 7 | Receive FIFO fill count, 0 to 64 |
| sw_rts | input | 1 | Software-controlled RTS value |
| rts_pin | output | 1 | RTS pin, 1 means busy |
| rx_irq | output | 1 | Receive trigger-level interrupt request |
| cts_pin | input | 1 | Asynchronous CTS pin, 1 means far end busy |
| tx_req | input | 1 | Serializer has a character ready to start |
| tx_busy | input | 1 | Serializer is shifting a character |
| tx_start | output | 1 | Permission to start the next character |

## Verification
Two functions can fall in the same cycle. A configuration write can change the trigger select or the RTS enable on the same edge where `rx_fill` crosses a ladder level. The random stimulus makes occasional writes while the fill performs a random walk with jumps across all rungs, so these coincidences occur many times. A reference model in the bench evaluates each edge using the configuration that held before the write. Every output is compared at the following negative edge. A directed case also disables automatic RTS while the pin is held busy, which must return the pin to `sw_rts` at once.

// File: rtl/fc_pkg.sv
// Package: shared configuration type and ladder helpers for the
// automatic flow-control block. Assumes a four-rung trigger ladder.
package fc_pkg;

    typedef struct packed {
        logic       cts_en;
        logic       rts_en;
        logic [1:0] trig;
    } fc_cfg_t;

    // Rung index above the selected one, saturating at the top rung.
    function automatic logic [1:0] rung_up(input logic [1:0] sel);
        return (sel == 2'd3) ? 2'd3 : sel + 2'd1;
    endfunction

    // Rung index below the selected one, saturating at the bottom rung.
    function automatic logic [1:0] rung_down(input logic [1:0] sel);
        return (sel == 2'd0) ? 2'd0 : sel - 2'd1;
    endfunction

    // Level in characters for a rung index, given the four ladder levels.
    function automatic int rung_level(input logic [1:0] sel, input int l0,
                                      input int l1, input int l2, input int l3);
        case (sel)
            2'd0:    return l0;
            2'd1:    return l1;
            2'd2:    return l2;
            default: return l3;
        endcase
    endfunction

endpackage

// File: rtl/fc_cfg_reg.sv
// Configuration register: stores the two enable bits and the trigger
// select. Assumes a single-cycle write strobe; clears on synchronous reset.
module fc_cfg_reg
    import fc_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int CTS_BIT   = 7,
    parameter int RTS_BIT   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output fc_cfg_t           cfg
);

    // Load the register on a write; reset everything to disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we) begin
            cfg.cts_en <= wdata[CTS_BIT];
            cfg.rts_en <= wdata[RTS_BIT];
            cfg.trig   <= wdata[1:0];
        end
    end

endmodule

// File: rtl/fc_sync.sv
// Multi-flop synchronizer for an asynchronous pin. Assumes the pin is
// slow compared with the clock; output lags the pin by STAGES edges.
module fc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    // Shift the pin value through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/fc_rx_ladder.sv
// Receive-side ladder: compares the FIFO fill with the trigger ladder.
// It keeps the RTS hold state with hysteresis and registers the interrupt.
// Assumes the fill count is already in this clock domain.
module fc_rx_ladder
    import fc_pkg::*;
#(
    parameter int FILL_W = 7,
    parameter int LVL0   = 8,
    parameter int LVL1   = 16,
    parameter int LVL2   = 56,
    parameter int LVL3   = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fc_cfg_t           cfg,
    input  logic [FILL_W-1:0] fill,
    output logic              hold,
    output logic              irq
);

    logic [FILL_W-1:0] trig_lvl, hi_lvl, lo_lvl;
    logic              at_trig, at_hi, below_lo;

    // Derive the trigger, assert and release levels from the select field.
    always_comb begin
        trig_lvl = FILL_W'(rung_level(cfg.trig, LVL0, LVL1, LVL2, LVL3));
        hi_lvl   = FILL_W'(rung_level(rung_up(cfg.trig), LVL0, LVL1, LVL2, LVL3));
        lo_lvl   = FILL_W'(rung_level(rung_down(cfg.trig), LVL0, LVL1, LVL2, LVL3));
        at_trig  = (fill >= trig_lvl);
        at_hi    = (fill >= hi_lvl);
        below_lo = (fill < lo_lvl);
    end

    // Hysteresis state: set at the upper rung, cleared below the lower rung.
    always_ff @(posedge clk) begin
        if (!rst_n || !cfg.rts_en) hold <= 1'b0;
        else if (at_hi)            hold <= 1'b1;
        else if (below_lo)         hold <= 1'b0;
    end

    // Interrupt request: high while the fill is at or above the trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= at_trig;
    end

endmodule

// File: rtl/fc_tx_gate.sv
// Transmit gate: allows a new character only at a boundary and only
// when automatic CTS is off or the synchronized CTS shows ready.
module fc_tx_gate (
    input  logic cts_en,
    input  logic cts_busy,
    input  logic req,
    input  logic busy,
    output logic start
);

    // Combine request, boundary and far-end readiness.
    always_comb start = req && !busy && !(cts_en && cts_busy);

endmodule

// File: rtl/uart_autoflow.sv
// Top of the automatic modem flow-control block. It ties the config
// register, the CTS synchronizer, the receive ladder and the transmit gate.
// Assumes rx_fill never exceeds the FIFO depth.
module uart_autoflow
    import fc_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int FILL_W     = $clog2(DEPTH + 1),
    parameter int SYNC_STAGES = 2,
    parameter int LVL0       = 8,
    parameter int LVL1       = 16,
    parameter int LVL2       = 56,
    parameter int LVL3       = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [FILL_W-1:0] rx_fill,
    input  logic              sw_rts,
    output logic              rts_pin,
    output logic              rx_irq,
    input  logic              cts_pin,
    input  logic              tx_req,
    input  logic              tx_busy,
    output logic              tx_start
);

    fc_cfg_t cfg_q;
    logic    cts_s;
    logic    rts_hold;

    fc_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg_q)
    );

    fc_sync #(.STAGES(SYNC_STAGES)) u_cts_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cts_pin),
        .dout  (cts_s)
    );

    fc_rx_ladder #(
        .FILL_W(FILL_W), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
    ) u_ladder (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg   (cfg_q),
        .fill  (rx_fill),
        .hold  (rts_hold),
        .irq   (rx_irq)
    );

    fc_tx_gate u_gate (
        .cts_en   (cfg_q.cts_en),
        .cts_busy (cts_s),
        .req      (tx_req),
        .busy     (tx_busy),
        .start    (tx_start)
    );

    // Pin mux: hardware hold when enabled, software value otherwise.
    always_comb rts_pin = cfg_q.rts_en ? rts_hold : sw_rts;

    // Read-back: bit 6 mirrors the live hardware flow-control state.
    always_comb cfg_rdata = {cfg_q.cts_en, cfg_q.rts_en && rts_hold, 4'b0000, cfg_q.trig};

endmodule

// File: rtl/fc_checker.sv
// Property checker for uart_autoflow, attached by bind below.
module fc_checker
    import fc_pkg::*;
#(
    parameter int FILL_W = 7,
    parameter int LVL0   = 8,
    parameter int LVL1   = 16,
    parameter int LVL2   = 56,
    parameter int LVL3   = 60
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        cfg_rdata,
    input logic              auto_rts_en,
    input logic [FILL_W-1:0] rx_fill,
    input logic              sw_rts,
    input logic              rts_pin,
    input logic              rx_irq,
    input logic              cts_pin,
    input logic              tx_busy,
    input logic              tx_start
);

    logic [1:0] cyc;
    int         hi, lo, tr;

    // Count edges since reset, saturating, to guard history-based checks.
    always_ff @(posedge clk) begin
        if (!rst_n)         cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    always_comb begin
        tr = rung_level(cfg_rdata[1:0], LVL0, LVL1, LVL2, LVL3);
        hi = rung_level(rung_up(cfg_rdata[1:0]), LVL0, LVL1, LVL2, LVL3);
        lo = rung_level(rung_down(cfg_rdata[1:0]), LVL0, LVL1, LVL2, LVL3);
    end

    assert_cts_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && cfg_rdata[7] && cts_pin && $past(cts_pin) && $past(cts_pin, 2))
        |-> !tx_start);

    assert_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> !tx_start);

    assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 2'd0) |=> (rx_irq == (int'($past(rx_fill)) >= $past(tr))));

    assert_rts_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && int'(rx_fill) >= hi) |=> (!auto_rts_en || rts_pin));

    assert_rts_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && rts_pin && int'(rx_fill) >= lo) |=> (!auto_rts_en || rts_pin));

    assert_rts_soft_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_rts_en |-> (rts_pin == sw_rts));

    assert_mirror_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[6] |-> (rts_pin && auto_rts_en));

endmodule

bind uart_autoflow fc_checker #(
    .FILL_W(FILL_W), .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
) u_fc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_rdata   (cfg_rdata),
    .auto_rts_en (cfg_q.rts_en),
    .rx_fill     (rx_fill),
    .sw_rts      (sw_rts),
    .rts_pin     (rts_pin),
    .rx_irq      (rx_irq),
    .cts_pin     (cts_pin),
    .tx_busy     (tx_busy),
    .tx_start    (tx_start)
);

// File: tb/tb_uart_autoflow.sv
// Bench for uart_autoflow: seeded random stimulus plus directed corners,
// compared against a cycle model built from the requirements.
module tb_uart_autoflow;

    localparam int CLK_PERIOD = 10;
    localparam int FILL_W     = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [7:0]        cfg_wdata = '0;
    logic [7:0]        cfg_rdata;
    logic [FILL_W-1:0] rx_fill = '0;
    logic              sw_rts = 1'b1;
    logic              rts_pin, rx_irq, tx_start;
    logic              cts_pin = 1'b0;
    logic              tx_req = 1'b0;
    logic              tx_busy = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model state
    bit       m_cts_en, m_rts_en, m_s1, m_s2, m_hold, m_irq;
    bit [1:0] m_trig;

    uart_autoflow dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .rx_fill(rx_fill), .sw_rts(sw_rts),
        .rts_pin(rts_pin), .rx_irq(rx_irq), .cts_pin(cts_pin),
        .tx_req(tx_req), .tx_busy(tx_busy), .tx_start(tx_start)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int lvl(input int r);
        case (r)
            0: return 8;
            1: return 16;
            2: return 56;
            default: return 60;
        endcase
    endfunction

    function automatic int hi_of(input int s); return lvl(s == 3 ? 3 : s + 1); endfunction
    function automatic int lo_of(input int s); return lvl(s == 0 ? 0 : s - 1); endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_cts_en = 0; m_rts_en = 0; m_trig = 0;
        m_s1 = 0; m_s2 = 0; m_hold = 0; m_irq = 0;
    endtask

    // One cycle: drive at negedge, compare, then advance the model at posedge.
    task automatic step(input bit we, input bit [7:0] wd, input int fill,
                        input bit sw, input bit cts, input bit req, input bit busy);
        int f;
        @(negedge clk);
        cfg_we = we; cfg_wdata = wd; rx_fill = FILL_W'(fill);
        sw_rts = sw; cts_pin = cts; tx_req = req; tx_busy = busy;
        #1;
        check("R3 R4 tx_start", tx_start, int'(req && !busy && !(m_cts_en && m_s2)));
        check("R6 R7 rts_pin", rts_pin, int'(m_rts_en ? m_hold : sw));
        check("R5 rx_irq", rx_irq, int'(m_irq));
        check("R2 R8 cfg_rdata", cfg_rdata,
              int'({m_cts_en, m_rts_en && m_hold, 4'b0000, m_trig}));
        @(posedge clk);
        f = fill;
        if (!m_rts_en)              m_hold = 0;
        else if (f >= hi_of(m_trig)) m_hold = 1;
        else if (f < lo_of(m_trig))  m_hold = 0;
        m_irq = (f >= lvl(m_trig));
        m_s2 = m_s1; m_s1 = cts;
        if (we) begin
            m_cts_en = wd[7]; m_rts_en = wd[6]; m_trig = wd[1:0];
        end
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int fill;
        bit sw, cts, we;
        bit [7:0] wd;
        void'($urandom(32'd1234));
        model_reset();
        // R1: reset state, checked while reset is held
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R1 cfg_rdata", cfg_rdata, 0);
        check("R1 rx_irq", rx_irq, 0);
        check("R1 rts_pin", rts_pin, 1);
        rst_n = 1'b1;

        // R2: write all fields, unused bits must read 0
        step(1, 8'hFF, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        // R6: top rung, assert saturates at 60, release at 56
        step(1, 8'h43, 0, 0, 0, 0, 0);
        step(0, 0, 59, 0, 0, 0, 0);
        step(0, 0, 60, 0, 0, 0, 0);
        step(0, 0, 56, 0, 0, 0, 0);
        step(0, 0, 55, 0, 0, 0, 0);
        step(0, 0, 55, 0, 0, 0, 0);
        // R6: bottom rung, assert at 16, release saturates at 8
        step(1, 8'h40, 16, 0, 0, 0, 0);
        step(0, 0, 16, 0, 0, 0, 0);
        step(0, 0, 8, 0, 0, 0, 0);
        step(0, 0, 7, 0, 0, 0, 0);
        step(0, 0, 7, 0, 0, 0, 0);
        // R7 R8: disable while held busy returns the pin to software
        step(0, 0, 40, 0, 0, 0, 0);
        step(1, 8'h00, 40, 0, 0, 0, 0);
        step(0, 0, 40, 0, 0, 0, 0);
        step(0, 0, 40, 1, 0, 0, 0);
        // R3 R4: CTS busy during a character, then at the boundary
        step(1, 8'h80, 0, 0, 1, 1, 1);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 1, i < 2);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 1, 0);
        // R3: CTS ignored with the enable off
        step(1, 8'h00, 0, 0, 1, 1, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 1, 0);

        // Random phase: fill walk with jumps, sparse config writes
        fill = 0; sw = 0; cts = 0;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(15) == 0) fill = $urandom_range(64);
            else fill = fill + int'($urandom_range(6)) - 3;
            if (fill < 0) fill = 0;
            if (fill > 64) fill = 64;
            if ($urandom_range(7) == 0)  sw  = !sw;
            if ($urandom_range(5) == 0)  cts = !cts;
            we = ($urandom_range(19) == 0);
            wd = 8'($urandom());
            step(we, wd, fill, sw, cts, 1'($urandom()), 1'($urandom()));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule